// File: doc/BRIEF.md
# Multi-context accelerator job controller

This block is the control-plane slave that sits between a peripheral register bus and a hardware accelerator inside a shared-memory processor cluster. It keeps four job contexts. Each context is a full copy of the accelerator's parameter registers: a set of I/O pointer words followed by a set of generic parameter words. Because there are several contexts, more than one processing element can prepare work while a job is already running.

A core reserves a context by reading the acquire register. The read returns the context number, or the locked code when no context is free, in which case the core retries later. The core then fills in the parameters of that context and writes the context number to the trigger register. Triggered contexts wait in a first-in first-out queue. The controller pulses the accelerator's start input for the oldest one and drives that context's parameters onto the accelerator parameter bus while the job runs. When the accelerator reports done, every core receives an end-of-job event and the context returns to the free pool.

Top module: `acc_job_ctrl`

## Requirements
- R1: After reset all four contexts are free. The status word (word address 0x03) reads 0x0000_0004 (bits [7:0] hold the free-context count, bit 8 is busy). The running word (0x02) reads 0xFFFF_FFFF. acc_start and evt_o are low.
- R2: Every read request is answered by bus_rvalid and bus_rdata in the cycle after the request. A read of the acquire word (0x00) returns the lowest-numbered free context and marks it acquired, so four reads in a row return 0, 1, 2 and 3.
- R3: When no context is free, an acquire read returns 0xFFFF_FFFE and changes no context state.
- R4: A write to parameter address 0x40 + 16*ctx + reg, with reg below 7 (0 to 2 are the pointers, 3 to 6 are the generic words), stores the data only while the context is acquired. A read of the same address returns the stored value, which is 0 after reset. A write to a context that is not in the acquired state leaves the stored value unchanged.
- R5: A write to the trigger word (0x01) names a context in wdata[1:0]. If that context is acquired, the context is queued. When the accelerator is idle, acc_start pulses for exactly one cycle, in the second cycle after the write is sampled. While a job runs, acc_params carries the parameters of the running context, with register k in bits [32k+31:32k].
- R6: A trigger that names a context which is not acquired is ignored. No start pulse follows and the status word does not change.
- R7: Queued contexts start in the order in which they were triggered.
- R8: acc_done sampled while a job runs makes all bits of evt_o high for one cycle and frees the context. If another job is queued, acc_start pulses in the cycle after that event.
- R9: While a job runs, the running word returns the identifier of its context. It returns 0xFFFF_FFFF when nothing runs.
- R10: Status bits [7:0] give the number of free contexts. Status bit 8 is high while any context is queued or running.
- R11: acc_done while no job runs is ignored and produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a read request |
| acc_start | output | 1 | One-cycle start pulse to the accelerator |
| acc_params | output | 224 | Parameter words of the running context |
| acc_done | input | 1 | Job completion from the accelerator |
| evt_o | output | 16 | End-of-job event, one bit per processing element |

## Verification
The checker assumes that acc_done is raised only as a single-cycle pulse and only while a job is running or idle. It never assumes acc_done in the same cycle as the start pulse. It also assumes that bus requests last one cycle. The bench keeps to these assumptions by driving bus accesses through tasks that hold bus_req for exactly one cycle. It raises acc_done for one cycle only, and only after the start pulse has been observed, except for the deliberate idle pulse that exercises the ignore rule. Four rounds walk every context through acquire, fill, trigger and completion, each round with a different trigger permutation. Expected parameter words and context numbers are computed from the round and context indices.

// File: rtl/acc_job_pkg.sv
package acc_job_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // control word addresses
    localparam logic [ADDR_W-1:0] ADDR_ACQ  = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_TRIG = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_RUN  = 8'h02;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h03;

    localparam logic [DATA_W-1:0] ACQ_LOCKED = 32'hFFFF_FFFE;
    localparam logic [DATA_W-1:0] RUN_IDLE   = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        CTX_FREE = 2'd0,
        CTX_HELD = 2'd1,
        CTX_BUSY = 2'd2
    } ctx_state_e;

    typedef struct packed {
        logic                  req;
        logic                  we;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] status_word(input logic busy,
                                                      input logic [7:0] free_n);
        return {23'd0, busy, free_n};
    endfunction

    function automatic logic is_param_addr(input logic [ADDR_W-1:0] a);
        return a[7:6] == 2'b01;
    endfunction

endpackage

// File: rtl/ctx_alloc.sv
module ctx_alloc
    import acc_job_pkg::*;
#(
    parameter int NUM_CTX = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acq_req,
    output logic                        acq_ok,
    output logic [$clog2(NUM_CTX)-1:0]  acq_id,
    input  logic                        trig_req,
    input  logic [$clog2(NUM_CTX)-1:0]  trig_id,
    output logic                        trig_ok,
    input  logic                        rel_req,
    input  logic [$clog2(NUM_CTX)-1:0]  rel_id,
    output logic [NUM_CTX-1:0]          held,
    output logic [$clog2(NUM_CTX+1)-1:0] free_cnt
);
    localparam int CW = $clog2(NUM_CTX);
    localparam int NW = $clog2(NUM_CTX + 1);

    ctx_state_e st [NUM_CTX];

    // lowest free context wins
    always_comb begin
        acq_ok = 1'b0;
        acq_id = '0;
        for (int c = NUM_CTX - 1; c >= 0; c--) begin
            if (st[c] == CTX_FREE) begin
                acq_ok = 1'b1;
                acq_id = CW'(c);
            end
        end
    end

    always_comb begin
        free_cnt = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (st[c] == CTX_FREE) free_cnt = free_cnt + NW'(1);
        end
    end

    assign trig_ok = trig_req && (st[trig_id] == CTX_HELD);

    generate
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            assign held[c] = (st[c] == CTX_HELD);
            always_ff @(posedge clk) begin
                if (rst) begin
                    st[c] <= CTX_FREE;
                end else if (rel_req && rel_id == CW'(c)) begin
                    st[c] <= CTX_FREE;
                end else if (acq_req && acq_ok && acq_id == CW'(c)) begin
                    st[c] <= CTX_HELD;
                end else if (trig_ok && trig_id == CW'(c)) begin
                    st[c] <= CTX_BUSY;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/job_fifo.sv
module job_fifo #(
    parameter int DEPTH = 4,
    parameter int IDW   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic [IDW-1:0] head_id,
    output logic           empty
);
    localparam int PW = $clog2(DEPTH);

    logic [IDW-1:0] q [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [PW:0]    cnt;

    assign head_id = q[rp];
    assign empty   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            if (push) begin
                q[wp] <= push_id;
                wp    <= wp + PW'(1);
            end
            if (pop) rp <= rp + PW'(1);
            case ({push, pop})
                2'b10:   cnt <= cnt + (PW+1)'(1);
                2'b01:   cnt <= cnt - (PW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/ctx_param_rf.sv
module ctx_param_rf
    import acc_job_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int NREG    = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_CTX)-1:0]  wr_ctx,
    input  logic [3:0]                  wr_reg,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [$clog2(NUM_CTX)-1:0]  rd_ctx,
    input  logic [3:0]                  rd_reg,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [$clog2(NUM_CTX)-1:0]  run_ctx,
    output logic [NREG*DATA_W-1:0]      run_params
);
    localparam int RW = $clog2(NREG);
    localparam logic [3:0] NREG4 = 4'(NREG);

    logic [DATA_W-1:0] mem [NUM_CTX][NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CTX; c++)
                for (int k = 0; k < NREG; k++)
                    mem[c][k] <= '0;
        end else if (wr_en) begin
            mem[wr_ctx][wr_reg[RW-1:0]] <= wr_data;
        end
    end

    assign rd_data = (rd_reg < NREG4) ? mem[rd_ctx][rd_reg[RW-1:0]] : '0;

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_out
            assign run_params[k*DATA_W +: DATA_W] = mem[run_ctx][k];
        end
    endgenerate

endmodule

// File: rtl/acc_job_ctrl.sv
module acc_job_ctrl
    import acc_job_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int NUM_PTR = 3,
    parameter int NUM_GEN = 4,
    parameter int NUM_PE  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  bus_req,
    input  logic                                  bus_we,
    input  logic [7:0]                            bus_addr,
    input  logic [31:0]                           bus_wdata,
    output logic [31:0]                           bus_rdata,
    output logic                                  bus_rvalid,
    output logic                                  acc_start,
    output logic [(NUM_PTR+NUM_GEN)*32-1:0]       acc_params,
    input  logic                                  acc_done,
    output logic [NUM_PE-1:0]                     evt_o
);
    localparam int NREG = NUM_PTR + NUM_GEN;
    localparam int CW   = $clog2(NUM_CTX);
    localparam int NW   = $clog2(NUM_CTX + 1);
    localparam logic [3:0] NREG4 = 4'(NREG);

    bus_req_t br;
    assign br = '{req: bus_req, we: bus_we, addr: bus_addr, wdata: bus_wdata};

    logic          is_rd, is_wr, in_param;
    logic [CW-1:0] p_ctx;
    logic [3:0]    p_reg;

    assign is_rd    = br.req && !br.we;
    assign is_wr    = br.req && br.we;
    assign in_param = is_param_addr(br.addr);
    assign p_ctx    = br.addr[4 +: CW];
    assign p_reg    = br.addr[3:0];

    // allocator
    logic              acq_req, acq_ok, trig_req, trig_ok;
    logic [CW-1:0]     acq_id;
    logic [NUM_CTX-1:0] held;
    logic [NW-1:0]     free_cnt;

    // run state
    logic          run_valid;
    logic [CW-1:0] run_id;
    logic          fifo_empty, pop, done_hit;
    logic [CW-1:0] head_id;

    assign acq_req  = is_rd && !in_param && (br.addr == ADDR_ACQ);
    assign trig_req = is_wr && !in_param && (br.addr == ADDR_TRIG);
    assign pop      = !run_valid && !fifo_empty;
    assign done_hit = acc_done && run_valid;

    ctx_alloc #(.NUM_CTX(NUM_CTX)) i_alloc (
        .clk      (clk),
        .rst      (rst),
        .acq_req  (acq_req),
        .acq_ok   (acq_ok),
        .acq_id   (acq_id),
        .trig_req (trig_req),
        .trig_id  (br.wdata[CW-1:0]),
        .trig_ok  (trig_ok),
        .rel_req  (done_hit),
        .rel_id   (run_id),
        .held     (held),
        .free_cnt (free_cnt)
    );

    job_fifo #(.DEPTH(NUM_CTX), .IDW(CW)) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (trig_ok),
        .push_id (br.wdata[CW-1:0]),
        .pop     (pop),
        .head_id (head_id),
        .empty   (fifo_empty)
    );

    logic              p_wr;
    logic [DATA_W-1:0] rf_rd;

    assign p_wr = is_wr && in_param && (p_reg < NREG4) && held[p_ctx];

    ctx_param_rf #(.NUM_CTX(NUM_CTX), .NREG(NREG)) i_rf (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (p_wr),
        .wr_ctx     (p_ctx),
        .wr_reg     (p_reg),
        .wr_data    (br.wdata),
        .rd_ctx     (p_ctx),
        .rd_reg     (p_reg),
        .rd_data    (rf_rd),
        .run_ctx    (run_id),
        .run_params (acc_params)
    );

    // job sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            run_valid <= 1'b0;
            run_id    <= '0;
            acc_start <= 1'b0;
            evt_o     <= '0;
        end else begin
            acc_start <= pop;
            evt_o     <= {NUM_PE{done_hit}};
            if (done_hit) begin
                run_valid <= 1'b0;
            end else if (pop) begin
                run_valid <= 1'b1;
                run_id    <= head_id;
            end
        end
    end

    // read path
    logic [DATA_W-1:0] rd_next;
    logic              busy;

    assign busy = run_valid || !fifo_empty;

    always_comb begin
        rd_next = '0;
        if (in_param) begin
            rd_next = rf_rd;
        end else begin
            case (br.addr)
                ADDR_ACQ:  rd_next = acq_ok ? DATA_W'(acq_id) : ACQ_LOCKED;
                ADDR_RUN:  rd_next = run_valid ? DATA_W'(run_id) : RUN_IDLE;
                ADDR_STAT: rd_next = status_word(busy, 8'(free_cnt));
                default:   rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= is_rd;
            if (is_rd) bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/acc_job_ctrl_chk.sv
module acc_job_ctrl_chk #(
    parameter int NUM_CTX = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_req,
    input logic                         bus_we,
    input logic                         bus_rvalid,
    input logic                         acc_start,
    input logic                         acc_done,
    input logic                         evt0,
    input logic                         run_valid,
    input logic [$clog2(NUM_CTX+1)-1:0] free_cnt
);
    assert_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        acc_start |=> !acc_start);

    assert_start_idle_R7: assert property (@(posedge clk) disable iff (rst)
        acc_start |-> !$past(run_valid));

    assert_evt_cause_R8: assert property (@(posedge clk) disable iff (rst)
        evt0 |-> $past(acc_done && run_valid));

    assert_evt_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (acc_done && !run_valid) |=> !evt0);

    assert_free_bound_R10: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= ($clog2(NUM_CTX+1))'(NUM_CTX));

endmodule

bind acc_job_ctrl acc_job_ctrl_chk #(.NUM_CTX(NUM_CTX)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_rvalid (bus_rvalid),
    .acc_start  (acc_start),
    .acc_done   (acc_done),
    .evt0       (evt_o[0]),
    .run_valid  (run_valid),
    .free_cnt   (free_cnt)
);

// File: tb/test_acc_job_ctrl.sv
`timescale 1ns/1ps
module test_acc_job_ctrl;

    localparam int NREG = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              acc_start;
    logic [NREG*32-1:0] acc_params;
    logic              acc_done = 1'b0;
    logic [15:0]       evt_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    acc_job_ctrl i_acc_job_ctrl (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .acc_start(acc_start), .acc_params(acc_params),
        .acc_done(acc_done), .evt_o(evt_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R2 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    function automatic logic [31:0] pv(input int r, input int c, input int k);
        return 32'hA000_0000 ^ (32'(r) << 16) ^ (32'(c) << 8) ^ 32'(k * 3 + 1);
    endfunction

    function automatic logic [7:0] paddr(input int c, input int k);
        return 8'h40 | 8'(c << 4) | 8'(k);
    endfunction

    function automatic int ord(input int r, input int i);
        return (r % 2 == 0) ? ((i + r) % 4) : ((3 - i + r) % 4);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 start low", 32'(acc_start), 32'd0);
        chk("R1 evt low", 32'(evt_o), 32'd0);
        rd(8'h03, d); chk("R1 status", d, 32'h0000_0004);
        rd(8'h02, d); chk("R1 running idle", d, 32'hFFFF_FFFF);

        // R6 trigger on a context that was never acquired
        wr(8'h01, 32'd2);
        for (int i = 0; i < 3; i++) begin
            chk("R6 no start", 32'(acc_start), 32'd0);
            @(negedge clk);
        end
        rd(8'h03, d); chk("R6 status unchanged", d, 32'h0000_0004);

        // R11 done while idle
        @(negedge clk); acc_done = 1'b1;
        @(negedge clk); acc_done = 1'b0;
        chk("R11 no event", 32'(evt_o), 32'd0);

        // R4 write to a free context is dropped
        wr(paddr(1, 0), 32'h5);
        rd(paddr(1, 0), d); chk("R4 ignored write", d, 32'd0);

        for (int r = 0; r < 4; r++) begin
            // R2 acquire order
            for (int c = 0; c < 4; c++) begin
                rd(8'h00, d); chk("R2 acquire id", d, 32'(c));
            end
            // R3 locked
            rd(8'h00, d); chk("R3 locked code", d, 32'hFFFF_FFFE);
            rd(8'h03, d); chk("R3 R10 status after lock", d, 32'h0000_0000);

            // R4 parameter fill and readback
            for (int c = 0; c < 4; c++)
                for (int k = 0; k < NREG; k++)
                    wr(paddr(c, k), pv(r, c, k));
            for (int c = 0; c < 4; c++) begin
                rd(paddr(c, (c + r) % NREG), d);
                chk("R4 readback", d, pv(r, c, (c + r) % NREG));
            end

            // R5 first trigger timing
            wr(8'h01, 32'(ord(r, 0)));
            chk("R5 start not early", 32'(acc_start), 32'd0);
            @(negedge clk);
            chk("R5 start pulse", 32'(acc_start), 32'd1);
            @(negedge clk);
            chk("R5 start one cycle", 32'(acc_start), 32'd0);
            for (int i = 1; i < 4; i++) wr(8'h01, 32'(ord(r, i)));
            rd(8'h02, d); chk("R9 running id", d, 32'(ord(r, 0)));
            rd(8'h03, d); chk("R10 status busy", d, 32'h0000_0100);

            for (int i = 0; i < 4; i++) begin
                for (int k = 0; k < NREG; k++)
                    chk("R5 params", acc_params[k*32 +: 32], pv(r, ord(r, i), k));
                @(negedge clk); acc_done = 1'b1;
                @(negedge clk); acc_done = 1'b0;
                chk("R8 event broadcast", 32'(evt_o), 32'h0000_FFFF);
                chk("R8 no start with event", 32'(acc_start), 32'd0);
                @(negedge clk);
                chk("R8 event one cycle", 32'(evt_o), 32'd0);
                chk("R8 next start", 32'(acc_start), (i < 3) ? 32'd1 : 32'd0);
                if (i < 3) begin
                    rd(8'h02, d); chk("R7 fifo order", d, 32'(ord(r, i + 1)));
                end
                rd(8'h03, d);
                chk("R10 free count", d, {23'd0, (i < 3), 8'(i + 1)});
            end
            rd(8'h02, d); chk("R9 idle after jobs", d, 32'hFFFF_FFFF);
        end

        // R4 freed context keeps last value
        wr(paddr(1, 0), 32'h1234);
        rd(paddr(1, 0), d); chk("R4 freed context", d, pv(3, 1, 0));

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule